// File: doc/BRIEF.md
# Sensor Frame Capture Gate

The block sits between a grayscale image sensor and a downstream processing block and runs on the clock that the processing block supplies. The sensor drives an 8-bit pixel bus that the block samples on every rising clock edge. A line-active level is high while the pixels of a row are on the bus, and a frame-sync level rises once at the start of every frame. The block decides once per frame, at the frame-sync rising edge, whether the whole frame is passed on or thrown away. It then forwards every pixel of an accepted frame with a one-cycle valid strobe. The first pixel is marked as start of frame, and acceptance is signalled by a one-cycle new-frame pulse.

The output is a valid/ready stream whose ready acts per frame, not per beat. The consumer raises `cons_ready_i` to say it can take a whole frame. The block samples that level only in the cycle where frame-sync rises: high admits the coming frame, low drops all of it. Once a frame is admitted, its pixels are delivered at sensor rate whatever `cons_ready_i` does. A sensor cannot be stalled, so a change of ready in mid-frame only affects the next frame. After reset the block forwards nothing until a frame-sync rising edge, so a frame already in progress at reset is never passed on half-done.

The block also counts pixels per row and rows per frame against the `COLS` and `ROWS` parameters, which default to 126 and 98. Any frame whose shape differs raises a sticky error flag, whether that frame was admitted or dropped.

Top module: `frame_capture_gate`

## Requirements
- R1: After reset, `pix_valid_o`, `sof_o`, `new_frame_o` and `geom_err_o` are low. No pixel is forwarded until a frame-sync rising edge has been seen after reset, even with `cons_ready_i` high.
- R2: When `cons_ready_i` is high in the cycle where `frame_i` rises, `new_frame_o` pulses in the next cycle. Every later cycle with `line_i` high in that frame gives `pix_valid_o` high one cycle later, with `pix_o` equal to the sampled pixel.
- R3: When `cons_ready_i` is low in the cycle where `frame_i` rises, no `new_frame_o` pulse follows and `pix_valid_o` stays low for that entire frame.
- R4: A change of `cons_ready_i` in mid-frame neither cuts an admitted frame short nor admits a dropped one. It takes effect at the next frame-sync rising edge.
- R5: `sof_o` is high together with `pix_valid_o` on the first forwarded pixel of an admitted frame only, so exactly once per admitted frame.
- R6: When `line_i` falls after a row whose count of line-active cycles differs from `COLS`, `geom_err_o` goes high one cycle after the first cycle with `line_i` low. Rows before the first frame-sync rising edge after reset are not checked.
- R7: When `frame_i` rises and the previous frame held a number of rows (falling edges of `line_i`) different from `ROWS`, `geom_err_o` goes high one cycle later.
- R8: `geom_err_o` stays high once set, through any number of later correct frames, until reset clears it.
- R9: `frame_i` held high for several cycles counts as one frame start and gives a single one-cycle `new_frame_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the downstream block; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | PIX_W (8) | Sensor pixel bus |
| line_i | input | 1 | High while the pixels of a row are on `pix_i` |
| frame_i | input | 1 | Frame sync; its rising edge starts a frame |
| cons_ready_i | input | 1 | Consumer can take a whole frame; sampled at frame start only |
| pix_valid_o | output | 1 | One-cycle strobe per forwarded pixel |
| pix_o | output | PIX_W (8) | Forwarded pixel; meaningful while `pix_valid_o` is high |
| sof_o | output | 1 | Marks the first forwarded pixel of a frame |
| new_frame_o | output | 1 | One-cycle pulse when a frame is admitted |
| geom_err_o | output | 1 | Sticky flag: a row or frame had the wrong size |

## Verification
Every result lies exactly one register stage behind its cause. A pixel, its start-of-frame mark and the new-frame pulse appear in the cycle after the input cycle that carried them. A column error appears one cycle after the first line-low cycle of the faulty row. A row error appears one cycle after the frame-sync rise that closes the faulty frame. The bench updates a behavioural model at each rising edge from the inputs sampled there and compares all outputs 2 ns later, so every expected value lands in the cycle the design must produce it. Inputs change only on falling edges. Per-frame tallies of strobes and pulses, and error-flag checks at frame ends, tie the admit, drop and error cases to their requirements.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  // Width of a saturating counter able to hold the value lim plus one.
  function automatic int cnt_width(input int lim);
    return $clog2(lim + 1) + 1;
  endfunction
endpackage

// File: rtl/fcap_edge.sv
module fcap_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[i] <= 1'b0;
        else        prev_q[i] <= sig_i[i];
      end
      assign rise_o[i] = sig_i[i] & ~prev_q[i];
      assign fall_o[i] = ~sig_i[i] & prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/fcap_admit.sv
module fcap_admit (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rise_i,
  input  logic ready_i,
  input  logic line_i,
  output logic seen_o,
  output logic fwd_o,
  output logic sof_o,
  output logic admit_o
);
  logic pass_q, first_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q  <= 1'b0;
      first_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (frame_rise_i) begin
      pass_q  <= ready_i;
      first_q <= ready_i;
      seen_q  <= 1'b1;
    end else if (fwd_o) begin
      first_q <= 1'b0;
    end
  end

  assign seen_o  = seen_q;
  assign fwd_o   = line_i & pass_q;
  assign sof_o   = fwd_o & first_q;
  assign admit_o = frame_rise_i & ready_i;

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !pass_q);
  assert_drop_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rise_i && !ready_i) |=> !pass_q);
  assert_hold_mid_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rise_i |=> $stable(pass_q));
endmodule

// File: rtl/fcap_geom.sv
module fcap_geom #(
  parameter int COLS = 126,
  parameter int ROWS = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seen_i,
  input  logic line_i,
  input  logic line_fall_i,
  input  logic frame_rise_i,
  output logic err_o
);
  localparam int CW = fcap_pkg::cnt_width(COLS);
  localparam int RW = fcap_pkg::cnt_width(ROWS);
  localparam logic [CW-1:0] COLS_V = CW'(COLS);
  localparam logic [RW-1:0] ROWS_V = RW'(ROWS);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          err_q;
  logic          bad_row, bad_frame;

  assign bad_row   = seen_i & line_fall_i & (col_q != COLS_V);
  assign bad_frame = seen_i & frame_rise_i & (row_q != ROWS_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (bad_row || bad_frame) err_q <= 1'b1;
      if (frame_rise_i) begin
        col_q <= '0;
        row_q <= '0;
      end else begin
        if (line_fall_i) begin
          col_q <= '0;
          if (row_q != '1) row_q <= row_q + 1'b1;
        end else if (line_i && seen_i && col_q != '1) begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign err_o = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(line_fall_i || frame_rise_i));
endmodule

// File: rtl/frame_capture_gate.sv
module frame_capture_gate #(
  parameter int PIX_W = 8,
  parameter int COLS  = 126,
  parameter int ROWS  = 98
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             line_i,
  input  logic             frame_i,
  input  logic             cons_ready_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             sof_o,
  output logic             new_frame_o,
  output logic             geom_err_o
);
  localparam int SYNC_LINE  = 0;
  localparam int SYNC_FRAME = 1;

  logic [1:0] rise, fall;
  logic       seen, fwd, sof_c, admit;

  fcap_edge #(.N(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({frame_i, line_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  fcap_admit u_admit (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_rise_i (rise[SYNC_FRAME]),
    .ready_i      (cons_ready_i),
    .line_i       (line_i),
    .seen_o       (seen),
    .fwd_o        (fwd),
    .sof_o        (sof_c),
    .admit_o      (admit)
  );

  fcap_geom #(.COLS(COLS), .ROWS(ROWS)) u_geom (
    .clk          (clk),
    .rst_n        (rst_n),
    .seen_i       (seen),
    .line_i       (line_i),
    .line_fall_i  (fall[SYNC_LINE]),
    .frame_rise_i (rise[SYNC_FRAME]),
    .err_o        (geom_err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o <= 1'b0;
      sof_o       <= 1'b0;
      new_frame_o <= 1'b0;
      pix_o       <= '0;
    end else begin
      pix_valid_o <= fwd;
      sof_o       <= sof_c;
      new_frame_o <= admit;
      if (fwd) pix_o <= pix_i;
    end
  end

  assert_valid_follows_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> $past(line_i));
  assert_sof_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> pix_valid_o);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    new_frame_o |=> !new_frame_o);
endmodule

// File: tb/test_frame_capture_gate.sv
module test_frame_capture_gate;
  localparam int PW = 8;
  localparam int NC = 6;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] pix = '0;
  logic line = 1'b0, frm = 1'b0, rdy = 1'b0;
  logic vld, sof, nfr, err;
  logic [PW-1:0] pout;

  always #2.5 clk = ~clk;

  frame_capture_gate #(.PIX_W(PW), .COLS(NC), .ROWS(NR)) i_frame_capture_gate (
    .clk(clk), .rst_n(rst_n), .pix_i(pix), .line_i(line), .frame_i(frm),
    .cons_ready_i(rdy), .pix_valid_o(vld), .pix_o(pout), .sof_o(sof),
    .new_frame_o(nfr), .geom_err_o(err)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  int n_vld = 0, n_sof = 0, n_nfr = 0;
  int seed = 1;

  // Behavioural reference model
  bit m_fp, m_lp, m_pass, m_first, m_seen, m_err;
  int m_cols, m_rows;
  bit e_vld, e_sof, e_nfr;
  int e_pix;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fp = 0; m_lp = 0; m_pass = 0; m_first = 0; m_seen = 0; m_err = 0;
      m_cols = 0; m_rows = 0; e_vld = 0; e_sof = 0; e_nfr = 0; e_pix = 0;
    end else begin
      bit fr_up, ln_dn;
      fr_up = frm && !m_fp;
      ln_dn = !line && m_lp;
      e_nfr = fr_up && rdy;
      e_vld = line && m_pass;
      e_sof = e_vld && m_first;
      if (e_vld) begin e_pix = pix; m_first = 0; end
      if (fr_up) begin
        if (m_seen && m_rows != NR) m_err = 1;
        m_pass = rdy; m_first = rdy; m_seen = 1; m_rows = 0; m_cols = 0;
      end else if (ln_dn) begin
        if (m_seen && m_cols != NC) m_err = 1;
        m_rows++; m_cols = 0;
      end else if (line && m_seen) begin
        m_cols++;
      end
      m_fp = frm; m_lp = line;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare, 2 ns after each rising edge
  always begin
    @(posedge clk); #2;
    if (rst_n) begin
      chk({cur_req, " pix_valid"}, int'(vld), int'(e_vld));
      chk({cur_req, " sof"}, int'(sof), int'(e_sof));
      chk({cur_req, " new_frame"}, int'(nfr), int'(e_nfr));
      chk({cur_req, " geom_err"}, int'(err), int'(m_err));
      if (e_vld) chk({cur_req, " pix"}, int'(pout), e_pix);
      if (vld) n_vld++;
      if (sof) n_sof++;
      if (nfr) n_nfr++;
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 0; line = 0; frm = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic clr();
    n_vld = 0; n_sof = 0; n_nfr = 0;
  endtask

  task automatic rows_only(int nrows, int bad_row, int rdy_mid);
    for (int r = 0; r < nrows; r++) begin
      if (r == 1) rdy = rdy_mid[0];
      for (int c = 0; c < ((r == bad_row) ? NC - 1 : NC); c++) begin
        @(negedge clk); line = 1; pix = PW'(seed); seed = seed * 5 + 3;
      end
      repeat (3) begin @(negedge clk); line = 0; end
    end
  endtask

  task automatic send_frame(int nrows, int bad_row, int rdy0, int rdy_mid, int vlen);
    @(negedge clk); rdy = rdy0[0]; frm = 1;
    repeat (vlen - 1) @(negedge clk);
    @(negedge clk); frm = 0;
    @(negedge clk);
    rows_only(nrows, bad_row, rdy_mid);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    cur_req = "R1";
    chk("R1 reset pix_valid", int'(vld), 0);
    chk("R1 reset new_frame", int'(nfr), 0);
    chk("R1 reset geom_err", int'(err), 0);
    clr(); rdy = 1;
    rows_only(2, -1, 1);
    chk("R1 no output before frame sync", n_vld, 0);

    cur_req = "R2"; clr();
    send_frame(NR, -1, 1, 1, 1);
    chk("R2 pixels forwarded", n_vld, NR * NC);
    chk("R2 new-frame pulses", n_nfr, 1);
    chk("R5 single sof", n_sof, 1);

    cur_req = "R3"; clr();
    send_frame(NR, -1, 0, 0, 1);
    chk("R3 dropped frame pixels", n_vld, 0);
    chk("R3 dropped frame pulses", n_nfr, 0);

    cur_req = "R4"; clr();
    send_frame(NR, -1, 1, 0, 1);
    chk("R4 ready low mid-frame keeps frame", n_vld, NR * NC);
    clr();
    send_frame(NR, -1, 0, 1, 1);
    chk("R4 ready high mid-frame admits nothing", n_vld, 0);

    cur_req = "R9"; clr();
    send_frame(NR, -1, 1, 1, 4);
    chk("R9 long sync single pulse", n_nfr, 1);
    chk("R5 sof once with long sync", n_sof, 1);
    chk("R9 pixels after long sync", n_vld, NR * NC);
    chk("R6 no error on good frames", int'(err), 0);

    cur_req = "R6"; clr();
    send_frame(NR, 2, 1, 1, 1);
    chk("R6 short row sets error", int'(err), 1);

    do_reset();
    #1;
    cur_req = "R8";
    chk("R8 reset clears error", int'(err), 0);
    chk("R1 reset clears valid", int'(vld), 0);

    cur_req = "R7"; clr();
    send_frame(NR, -1, 1, 1, 1);
    send_frame(NR - 1, -1, 1, 1, 1);
    chk("R7 no error before closing sync", int'(err), 0);
    send_frame(NR, -1, 1, 1, 1);
    chk("R7 short frame sets error", int'(err), 1);
    cur_req = "R8";
    send_frame(NR, -1, 1, 1, 1);
    send_frame(NR, -1, 1, 1, 1);
    chk("R8 error sticky over good frames", int'(err), 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule